// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches an SMBus segment and raises a timeout when the bus misbehaves in time. All counting happens on single-cycle pulses from an external prescaler, so one count is one prescaled time unit. A window counter compares against a 12-bit limit A. Depending on a mode select, it either measures how long SCL stays low without a break, or how long the bus has stayed idle with SCL and SDA both high.

Two accumulators compare against a 12-bit limit B. One adds up the clock-low stretching that the local master inserts. The other adds up the stretching that the local slave inserts. Each accumulator keeps its total across separate stretch intervals, and the total is discarded only at a message boundary.

When any armed check reaches its limit, a sticky timeout flag is set. Software clears the flag by pulsing a write-one-to-clear strobe. The flag drives an interrupt, which is gated by an error-interrupt enable.

Top module: `smbus_tmo_monitor`

## Requirements
- R1: A synchronous active-high reset clears the timeout flag, the interrupt and all counters. Both outputs are low on the cycle after any reset cycle.
- R2: With `idle_sel` = 0 and `win_en` = 1, the flag is set once `scl_in` has been low for `limit_a` tick pulses in a row. Any cycle with `scl_in` high restarts the count from zero.
- R3: With `idle_sel` = 1 and `win_en` = 1, the window counter advances only while both `scl_in` and `sda_in` are high. The flag is set when the counter reaches `limit_a`. A low level on either line restarts the count.
- R4: With `mst_ext_en` = 1, every tick that arrives while `mst_ext` is high is added to a master total. The total is kept across gaps in stretching, and the flag is set when it reaches `limit_b`.
- R5: With `slv_ext_en` = 1, the same accumulation is done on `slv_ext` into a separate slave total, also against `limit_b`.
- R6: A one-cycle pulse on `msg_start` or `msg_end` returns both totals to zero.
- R7: Each of the three checks has its own enable. While a check is disabled, its counter is held at zero and it never sets the flag. Its counter also ignores the other side's stretch indicator.
- R8: Counters move only on cycles with `tick` high, and by one count at a time. They stop at the limit instead of wrapping. A check that sits at its limit with its condition still true keeps requesting the flag.
- R9: A limit value of zero disarms every check that uses it.
- R10: The flag stays set until a cycle with `flag_clr` high. If a check is firing in that same cycle, the set takes priority and the flag stays high.
- R11: `tmo_irq` is registered and equals the next flag value ANDed with `err_irq_en`. While `err_irq_en` is low, `tmo_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled time-base pulse, one cycle wide |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| idle_sel | input | 1 | 0: window measures SCL low; 1: window measures bus idle |
| win_en | input | 1 | Enable for the limit A window check |
| mst_ext_en | input | 1 | Enable for the master stretch accumulator |
| slv_ext_en | input | 1 | Enable for the slave stretch accumulator |
| mst_ext | input | 1 | Local master is holding SCL low to stretch |
| slv_ext | input | 1 | Local slave is holding SCL low to stretch |
| msg_start | input | 1 | Message begins; clears stretch totals |
| msg_end | input | 1 | Message ends; clears stretch totals |
| limit_a | input | 12 | Window limit in ticks |
| limit_b | input | 12 | Cumulative stretch limit in ticks |
| err_irq_en | input | 1 | Error-interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Timeout interrupt |

## Verification
The hardest state to reach from the ports is a stretch accumulator whose total is built from several separate intervals. Between those intervals, the stretch indicator drops, ticks keep arriving, and nothing observable changes. The stimulus alternates stretch and non-stretch tick bursts that add up to exactly the limit, and it checks the flag both one tick short of the limit and at it. A second sequence issues a message boundary in the middle of a total to show that the earlier counts are discarded.

A saturated window counter is reached by running far past the limit and then pulsing the clear. The flag must survive that clear, and must drop only after the condition is broken.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
  localparam int unsigned LIMIT_W = 12;
  localparam int unsigned N_SIDES = 2;

  typedef enum logic {
    SIDE_MST = 1'b0,
    SIDE_SLV = 1'b1
  } ext_side_e;

  typedef struct packed {
    logic win;
    logic slv;
    logic mst;
  } tmo_src_t;
endpackage

// File: rtl/tmo_window_ctr.sv
module tmo_window_ctr #(
  parameter int unsigned LIMIT_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               enable,
  input  logic               idle_sel,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [LIMIT_W-1:0] limit,
  output logic               fire
);
  logic [LIMIT_W-1:0] cnt;
  logic               cond;
  logic               armed;

  // The qualifying level depends on the mode: SCL low, or the bus idle high.
  assign cond  = idle_sel ? (scl_in & sda_in) : ~scl_in;
  assign armed = enable && (limit != '0);

  always_ff @(posedge clk) begin
    if (rst || !armed || !cond) begin
      cnt <= '0;
    end else if (tick && (cnt < limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fire = armed && cond && (cnt >= limit);
endmodule

// File: rtl/tmo_extend_acc.sv
module tmo_extend_acc #(
  parameter int unsigned LIMIT_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               enable,
  input  logic               extend,
  input  logic               msg_bound,
  input  logic [LIMIT_W-1:0] limit,
  output logic               fire
);
  logic [LIMIT_W-1:0] total;
  logic               armed;

  assign armed = enable && (limit != '0);

  // The total survives gaps between stretch intervals; only a message
  // boundary, a disable or a reset drops it.
  always_ff @(posedge clk) begin
    if (rst || !armed || msg_bound) begin
      total <= '0;
    end else if (tick && extend && (total < limit)) begin
      total <= total + 1'b1;
    end
  end

  assign fire = armed && (total >= limit);
endmodule

// File: rtl/tmo_flag_irq.sv
module tmo_flag_irq #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] fire_vec,
  input  logic             flag_clr,
  input  logic             err_irq_en,
  output logic             tmo_flag,
  output logic             tmo_irq
);
  logic flag_n;

  // Set wins over clear.
  assign flag_n = (tmo_flag & ~flag_clr) | (|fire_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_flag <= 1'b0;
      tmo_irq  <= 1'b0;
    end else begin
      tmo_flag <= flag_n;
      tmo_irq  <= flag_n & err_irq_en;
    end
  end
endmodule

// File: rtl/smbus_tmo_monitor.sv
module smbus_tmo_monitor
  import smbus_tmo_pkg::*;
#(
  parameter int unsigned LIMIT_W = smbus_tmo_pkg::LIMIT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               idle_sel,
  input  logic               win_en,
  input  logic               mst_ext_en,
  input  logic               slv_ext_en,
  input  logic               mst_ext,
  input  logic               slv_ext,
  input  logic               msg_start,
  input  logic               msg_end,
  input  logic [LIMIT_W-1:0] limit_a,
  input  logic [LIMIT_W-1:0] limit_b,
  input  logic               err_irq_en,
  input  logic               flag_clr,
  output logic               tmo_flag,
  output logic               tmo_irq
);
  localparam int unsigned N_SRC = $bits(tmo_src_t);

  tmo_src_t           src;
  logic [N_SIDES-1:0] side_en;
  logic [N_SIDES-1:0] side_ext;
  logic [N_SIDES-1:0] side_fire;
  logic               msg_bound;
  logic               fire_any;

  assign side_en[SIDE_MST]  = mst_ext_en;
  assign side_en[SIDE_SLV]  = slv_ext_en;
  assign side_ext[SIDE_MST] = mst_ext;
  assign side_ext[SIDE_SLV] = slv_ext;
  assign msg_bound          = msg_start | msg_end;

  tmo_window_ctr #(.LIMIT_W(LIMIT_W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .enable   (win_en),
    .idle_sel (idle_sel),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .limit    (limit_a),
    .fire     (src.win)
  );

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    tmo_extend_acc #(.LIMIT_W(LIMIT_W)) u_acc (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .enable    (side_en[s]),
      .extend    (side_ext[s]),
      .msg_bound (msg_bound),
      .limit     (limit_b),
      .fire      (side_fire[s])
    );
  end

  assign src.mst  = side_fire[SIDE_MST];
  assign src.slv  = side_fire[SIDE_SLV];
  assign fire_any = |src;

  tmo_flag_irq #(.N_SRC(N_SRC)) u_flag (
    .clk        (clk),
    .rst        (rst),
    .fire_vec   (src),
    .flag_clr   (flag_clr),
    .err_irq_en (err_irq_en),
    .tmo_flag   (tmo_flag),
    .tmo_irq    (tmo_irq)
  );
endmodule

// File: rtl/smbus_tmo_monitor_chk.sv
module smbus_tmo_monitor_chk (
  input logic clk,
  input logic rst,
  input logic flag_clr,
  input logic err_irq_en,
  input logic fire_any,
  input logic tmo_flag,
  input logic tmo_irq
);
  // R1
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (!tmo_flag && !tmo_irq));
  // R10
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && !flag_clr) |=> tmo_flag);
  // R10: a firing check sets the flag even against a clear
  p_fire_sets_r10: assert property (@(posedge clk) disable iff (rst)
    fire_any |=> tmo_flag);
  // R11
  p_irq_gated_r11: assert property (@(posedge clk) disable iff (rst)
    !err_irq_en |=> !tmo_irq);
  // R11
  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (rst)
    tmo_irq |-> tmo_flag);
endmodule

module tmo_window_chk #(
  parameter int unsigned LIMIT_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               enable,
  input logic [LIMIT_W-1:0] limit,
  input logic [LIMIT_W-1:0] cnt
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R7
  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0));
  // R8: no advance without a tick
  p_tick_only_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(tick)) |-> (cnt <= $past(cnt)));
  // R8: advance by one at most
  p_step_one_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (cnt > $past(cnt))) |-> (cnt == LIMIT_W'($past(cnt) + 1'b1)));
  // R8: no growth past a steady limit
  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $stable(limit) && ($past(cnt) >= limit)) |-> (cnt <= $past(cnt)));
endmodule

bind smbus_tmo_monitor smbus_tmo_monitor_chk u_mon_chk (
  .clk        (clk),
  .rst        (rst),
  .flag_clr   (flag_clr),
  .err_irq_en (err_irq_en),
  .fire_any   (fire_any),
  .tmo_flag   (tmo_flag),
  .tmo_irq    (tmo_irq)
);

bind tmo_window_ctr tmo_window_chk #(.LIMIT_W(LIMIT_W)) u_win_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .enable (enable),
  .limit  (limit),
  .cnt    (cnt)
);

// File: tb/test_smbus_tmo_monitor.sv
module test_smbus_tmo_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst, tick, scl_in, sda_in, idle_sel, win_en, mst_ext_en, slv_ext_en;
  logic mst_ext, slv_ext, msg_start, msg_end, err_irq_en, flag_clr;
  logic [LW-1:0] limit_a, limit_b;
  logic tmo_flag, tmo_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_tmo_monitor i_smbus_tmo_monitor (
    .clk, .rst, .tick, .scl_in, .sda_in, .idle_sel, .win_en, .mst_ext_en,
    .slv_ext_en, .mst_ext, .slv_ext, .msg_start, .msg_end, .limit_a, .limit_b,
    .err_irq_en, .flag_clr, .tmo_flag, .tmo_irq
  );

  typedef struct packed {
    logic          idle;
    logic          en_a;
    logic          en_m;
    logic          en_s;
    logic          scl;
    logic          sda;
    logic          mext;
    logic          sext;
    logic [LW-1:0] la;
    logic [LW-1:0] lb;
    logic [7:0]    n;
    logic          exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0, 12'd5, 12'd0, 8'd5,  1'b1, 4'd2}, // R2 reach
    '{1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0, 12'd5, 12'd0, 8'd4,  1'b0, 4'd2}, // R2 one short
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1, 1'b0,1'b0, 12'd3, 12'd0, 8'd3,  1'b1, 4'd3}, // R3 idle
    '{1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0, 1'b0,1'b0, 12'd3, 12'd0, 8'd10, 1'b0, 4'd3}, // R3 SDA low
    '{1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1, 1'b0,1'b0, 12'd3, 12'd0, 8'd10, 1'b0, 4'd2}, // R2 SCL high
    '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 1'b1,1'b0, 12'd0, 12'd4, 8'd4,  1'b1, 4'd4}, // R4 master
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0, 1'b0,1'b1, 12'd0, 12'd6, 8'd5,  1'b0, 4'd5}, // R5 short
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0, 1'b0,1'b1, 12'd0, 12'd6, 8'd6,  1'b1, 4'd5}, // R5 reach
    '{1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0, 12'd2, 12'd0, 8'd10, 1'b0, 4'd7}, // R7 disabled
    '{1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0, 12'd0, 12'd0, 8'd10, 1'b0, 4'd9}, // R9 zero limit
    '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 1'b0,1'b1, 12'd0, 12'd2, 8'd5,  1'b0, 4'd7}  // R7 other side
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      tick = 1'b1;
      step(1);
      tick = 1'b0;
      step(1);
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Disable every check and clear the flag and the totals.
  task automatic quiesce();
    win_en = 1'b0; mst_ext_en = 1'b0; slv_ext_en = 1'b0;
    mst_ext = 1'b0; slv_ext = 1'b0; tick = 1'b0;
    flag_clr = 1'b1; msg_end = 1'b1;
    step(1);
    flag_clr = 1'b0; msg_end = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b0; scl_in = 1'b1; sda_in = 1'b1; idle_sel = 1'b0;
    win_en = 1'b0; mst_ext_en = 1'b0; slv_ext_en = 1'b0; mst_ext = 1'b0;
    slv_ext = 1'b0; msg_start = 1'b0; msg_end = 1'b0; err_irq_en = 1'b1;
    flag_clr = 1'b0; limit_a = '0; limit_b = '0;
    step(3);
    rst = 1'b0;
    check("R1 flag after reset", tmo_flag, 1'b0);
    check("R1 irq after reset", tmo_irq, 1'b0);

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      quiesce();
      idle_sel = VECS[i].idle; win_en = VECS[i].en_a;
      mst_ext_en = VECS[i].en_m; slv_ext_en = VECS[i].en_s;
      scl_in = VECS[i].scl; sda_in = VECS[i].sda;
      mst_ext = VECS[i].mext; slv_ext = VECS[i].sext;
      limit_a = VECS[i].la; limit_b = VECS[i].lb;
      step(1);
      tick_n(int'(VECS[i].n));
      check($sformatf("R%0d vec %0d flag", VECS[i].req, i), tmo_flag, VECS[i].exp);
      check($sformatf("R11 vec %0d irq", i), tmo_irq, VECS[i].exp);
    end

    // R2: a break in SCL low restarts the window
    quiesce();
    idle_sel = 1'b0; win_en = 1'b1; limit_a = 12'd5; scl_in = 1'b0;
    tick_n(3);
    scl_in = 1'b1; step(1); scl_in = 1'b0;
    tick_n(3);
    check("R2 restart after SCL high", tmo_flag, 1'b0);
    tick_n(2);
    check("R2 full window after restart", tmo_flag, 1'b1);

    // R3: SCL dropping in idle mode restarts the count
    quiesce();
    idle_sel = 1'b1; win_en = 1'b1; limit_a = 12'd4; scl_in = 1'b1; sda_in = 1'b1;
    tick_n(3);
    scl_in = 1'b0; step(1); scl_in = 1'b1;
    tick_n(3);
    check("R3 restart after SCL low", tmo_flag, 1'b0);
    tick_n(1);
    check("R3 idle reached", tmo_flag, 1'b1);
    idle_sel = 1'b0;

    // R4: stretch total kept across gaps
    quiesce();
    mst_ext_en = 1'b1; limit_b = 12'd5;
    mst_ext = 1'b1; tick_n(2);
    mst_ext = 1'b0; tick_n(3);
    mst_ext = 1'b1; tick_n(2);
    check("R4 total one short", tmo_flag, 1'b0);
    tick_n(1);
    check("R4 total reached across gaps", tmo_flag, 1'b1);

    // R6: message boundaries drop the totals
    quiesce();
    mst_ext_en = 1'b1; limit_b = 12'd4; mst_ext = 1'b1;
    tick_n(3);
    msg_start = 1'b1; step(1); msg_start = 1'b0;
    tick_n(3);
    check("R6 msg_start clears total", tmo_flag, 1'b0);
    tick_n(1);
    check("R6 count after msg_start", tmo_flag, 1'b1);
    quiesce();
    slv_ext_en = 1'b1; limit_b = 12'd4; slv_ext = 1'b1;
    tick_n(3);
    msg_end = 1'b1; step(1); msg_end = 1'b0;
    tick_n(3);
    check("R6 msg_end clears total", tmo_flag, 1'b0);

    // R8: no counting without ticks
    quiesce();
    win_en = 1'b1; limit_a = 12'd2; scl_in = 1'b0;
    step(30);
    check("R8 no advance without tick", tmo_flag, 1'b0);

    // R8 and R10: saturated check keeps firing, so a clear does not win
    tick_n(20);
    check("R8 fired past limit", tmo_flag, 1'b1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check("R10 set wins over clear while saturated", tmo_flag, 1'b1);
    scl_in = 1'b1; step(2);
    check("R10 sticky after condition ends", tmo_flag, 1'b1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check("R10 clear drops flag", tmo_flag, 1'b0);

    // R11: interrupt gating
    quiesce();
    err_irq_en = 1'b0; win_en = 1'b1; limit_a = 12'd2; scl_in = 1'b0;
    tick_n(2);
    check("R11 flag with irq disabled", tmo_flag, 1'b1);
    check("R11 irq masked", tmo_irq, 1'b0);
    err_irq_en = 1'b1; step(1);
    check("R11 irq follows enable", tmo_irq, 1'b1);

    // R1: reset mid-run
    rst = 1'b1; step(1); rst = 1'b0; scl_in = 1'b1;
    check("R1 flag cleared by reset", tmo_flag, 1'b0);
    check("R1 irq cleared by reset", tmo_irq, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule